// File: doc/BRIEF.md
# Factory Serial Number CRC Checker

This block validates a 64-bit factory serial number as it is read out of a memory, one byte at a time in read order. The first byte is a product family code. The next six bytes form a 48-bit unique number. The last byte is a CRC over the first seven bytes.

The block checks the family byte against a fixed code. It runs a reflected CRC-8 with polynomial x^8 + x^5 + x^4 + 1 over the first seven bytes, one bit per clock, and compares the result with the eighth byte. It also captures the unique number. When the check is complete, it raises a one-cycle done pulse and holds two verdict flags and the captured number until the next start.

A start pulse clears the block at any time, including in the middle of a check.

Top module: `sn_crc_check`

## Requirements
- R1: After reset, and in the cycle after a start pulse, the outputs are: ready_o=1, done_o=0, crc_ok_o=0, id_ok_o=0 and uid_o=0.
- R2: A byte is accepted on a clock edge where byte_valid_i and ready_o are both high and start_i is low. ready_o is low from the next cycle. For bytes 0 to 6, ready_o returns high after the 8th following clock edge. byte_valid_i is ignored while ready_o is low.
- R3: The CRC register starts at 00h. Each bit is processed least significant bit first with a right shift: the feedback bit is crc[0] XOR the data bit, and when the feedback bit is 1 the shifted register is XORed with 8Ch. crc_ok_o is 1 exactly when the CRC of bytes 0 to 6 equals byte 7.
- R4: id_ok_o is 1 exactly when byte 0 was A0h.
- R5: Byte k, for k from 1 to 6, appears at uid_o[8k-1:8k-8] once done_o has pulsed.
- R6: done_o is high for exactly one cycle, right after the 8th clock edge that follows acceptance of byte 7. crc_ok_o and id_ok_o take their verdicts in that same cycle.
- R7: After done_o, ready_o stays low and further byte_valid_i pulses are ignored. crc_ok_o, id_ok_o and uid_o hold their values until the next start.
- R8: A start pulse discards any partial check, and the next accepted byte is byte 0. A byte_valid_i in the same cycle as start_i is not accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Clear and restart at byte 0 |
| byte_valid_i | input | 1 | byte_i holds the next serial number byte |
| byte_i | input | 8 | Serial number byte |
| ready_o | output | 1 | A byte may be offered |
| done_o | output | 1 | One-cycle pulse: the verdict is ready |
| crc_ok_o | output | 1 | The CRC byte matched |
| id_ok_o | output | 1 | The family byte matched |
| uid_o | output | 48 | Captured unique number, byte 1 in the low bits |

## Verification
The bench builds the block with its default parameters:
- eight bytes per identifier,
- family code A0h,
- reflected feedback constant 8Ch.

With these values a full identifier takes about seventy clocks, so a few hundred randomized identifiers fit easily. The randomized identifiers mix correct and corrupted family and CRC bytes. Directed cases cover:
- all-zero and all-one unique numbers,
- single-bit CRC errors at either end of the byte,
- byte strobes during a busy byte,
- extra bytes after completion,
- a start pulse mid-byte,
- a start pulse coinciding with a strobe.

// File: rtl/sn_crc_check.sv
module sn_crc_check #(
  parameter int         NUM_BYTES   = 8,
  parameter logic [7:0] FAMILY_CODE = 8'hA0,
  parameter logic [7:0] POLY_REFL   = 8'h8C
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start_i,
  input  logic                       byte_valid_i,
  input  logic [7:0]                 byte_i,
  output logic                       ready_o,
  output logic                       done_o,
  output logic                       crc_ok_o,
  output logic                       id_ok_o,
  output logic [(NUM_BYTES-2)*8-1:0] uid_o
);
  localparam int UID_W = (NUM_BYTES - 2) * 8;
  localparam int IDX_W = $clog2(NUM_BYTES);

  logic             busy_q, complete_q, id_match_q, crc_match_q;
  logic [2:0]       bit_q;
  logic [IDX_W-1:0] idx_q;
  logic [7:0]       sh_q, crc_q;

  assign ready_o = !busy_q && !complete_q;

  wire       accept     = byte_valid_i && ready_o && !start_i;
  wire       last_bit   = busy_q && (bit_q == 3'd7);
  wire       final_byte = (idx_q == IDX_W'(NUM_BYTES - 1));
  wire       fb         = crc_q[0] ^ sh_q[0];
  wire [7:0] crc_step   = {1'b0, crc_q[7:1]} ^ (fb ? POLY_REFL : 8'h00);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0; complete_q <= 1'b0; id_match_q <= 1'b0; crc_match_q <= 1'b0;
      bit_q <= '0; idx_q <= '0; sh_q <= '0; crc_q <= '0;
      done_o <= 1'b0; crc_ok_o <= 1'b0; id_ok_o <= 1'b0; uid_o <= '0;
    end else if (start_i) begin
      busy_q <= 1'b0; complete_q <= 1'b0; id_match_q <= 1'b0; crc_match_q <= 1'b0;
      bit_q <= '0; idx_q <= '0; sh_q <= '0; crc_q <= '0;
      done_o <= 1'b0; crc_ok_o <= 1'b0; id_ok_o <= 1'b0; uid_o <= '0;
    end else begin
      done_o <= 1'b0;
      if (accept) begin
        sh_q   <= byte_i;
        busy_q <= 1'b1;
        bit_q  <= '0;
        if (idx_q == '0) id_match_q <= (byte_i == FAMILY_CODE);
        if (final_byte)  crc_match_q <= (crc_q == byte_i);
        for (int k = 1; k < NUM_BYTES - 1; k++)
          if (idx_q == IDX_W'(k)) uid_o[k*8-8 +: 8] <= byte_i;
      end
      if (busy_q) begin
        crc_q <= crc_step;
        sh_q  <= {1'b0, sh_q[7:1]};
        bit_q <= bit_q + 3'd1;
        if (last_bit) begin
          busy_q <= 1'b0;
          if (final_byte) begin
            complete_q <= 1'b1;
            done_o     <= 1'b1;
            crc_ok_o   <= crc_match_q;
            id_ok_o    <= id_match_q;
          end else begin
            idx_q <= idx_q + IDX_W'(1);
          end
        end
      end
    end
  end

  AST_ACCEPT_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_valid_i && ready_o && !start_i) |=> !ready_o); // R2
  AST_CRC_RESIDUE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (crc_ok_o == (crc_q == 8'h00))); // R3
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R6
  AST_DONE_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !ready_o); // R7
  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (ready_o && !done_o && !crc_ok_o && !id_ok_o && uid_o == '0)); // R8
endmodule

// File: tb/sim_sn_crc_check.sv
module sim_sn_crc_check;
  logic clk = 1'b0, rst_n = 1'b0, start_i = 1'b0, byte_valid_i = 1'b0;
  logic [7:0] byte_i = '0;
  logic ready_o, done_o, crc_ok_o, id_ok_o;
  logic [47:0] uid_o;
  int n_chk = 0, n_fail = 0, cyc = 0;
  logic [7:0] vec [8];

  sn_crc_check u0 (.clk, .rst_n, .start_i, .byte_valid_i, .byte_i,
                   .ready_o, .done_o, .crc_ok_o, .id_ok_o, .uid_o);

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected under 150000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  function automatic logic [7:0] crc_ref(input int n);
    logic [7:0] c = 8'h00;
    for (int i = 0; i < n; i++)
      for (int j = 0; j < 8; j++) begin
        logic f = c[0] ^ vec[i][j];
        c = c >> 1;
        if (f) c = c ^ 8'h8C;
      end
    return c;
  endfunction

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic make_vec(input bit good_id, input bit good_crc);
    vec[0] = good_id ? 8'hA0 : 8'($urandom_range(0, 254));
    if (!good_id && vec[0] == 8'hA0) vec[0] = 8'hA1;
    for (int i = 1; i < 7; i++) vec[i] = 8'($urandom);
    vec[7] = crc_ref(7);
    if (!good_crc) vec[7] = vec[7] ^ (8'h01 << $urandom_range(0, 7));
  endtask

  task automatic pulse_start();
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk("R1", "ready after start", 64'(ready_o), 1);
    chk("R1", "flags after start", {61'd0, done_o, crc_ok_o, id_ok_o}, 0);
    chk("R1", "uid after start", 64'(uid_o), 0);
  endtask

  task automatic send_byte(input logic [7:0] b, input bit last, input bit noise);
    int w = 0;
    while (!ready_o && w < 50) begin @(negedge clk); w++; end
    byte_valid_i = 1'b1; byte_i = b;
    @(negedge clk);
    byte_valid_i = 1'b0;
    chk("R2", "ready low after accept", 64'(ready_o), 0);
    if (noise) begin
      repeat (2) @(negedge clk);
      byte_valid_i = 1'b1; byte_i = ~b;
      @(negedge clk);
      byte_valid_i = 1'b0;
      repeat (5) @(negedge clk);
    end else begin
      repeat (8) @(negedge clk);
    end
    if (last) begin
      chk("R6", "done after final byte", 64'(done_o), 1);
      chk("R7", "ready low when complete", 64'(ready_o), 0);
    end else begin
      chk("R2", "ready back after 8 clocks", 64'(ready_o), 1);
      chk("R6", "no early done", 64'(done_o), 0);
    end
  endtask

  task automatic run_vector(input bit do_start, input bit noise, input bit extra);
    logic exp_crc = (crc_ref(7) == vec[7]);
    logic exp_id  = (vec[0] == 8'hA0);
    logic [47:0] exp_uid = {vec[6], vec[5], vec[4], vec[3], vec[2], vec[1]};
    if (do_start) pulse_start();
    for (int i = 0; i < 8; i++) send_byte(vec[i], i == 7, noise);
    chk("R3", "crc_ok", 64'(crc_ok_o), 64'(exp_crc));
    chk("R4", "id_ok", 64'(id_ok_o), 64'(exp_id));
    chk("R5", "uid", 64'(uid_o), 64'(exp_uid));
    @(negedge clk);
    chk("R6", "done lasts one cycle", 64'(done_o), 0);
    if (extra) begin
      byte_valid_i = 1'b1; byte_i = ~vec[0];
      @(negedge clk);
      byte_valid_i = 1'b0;
      repeat (10) @(negedge clk);
      chk("R7", "ready held low", 64'(ready_o), 0);
      chk("R7", "flags held", {62'd0, crc_ok_o, id_ok_o}, {62'd0, exp_crc, exp_id});
      chk("R7", "uid held", 64'(uid_o), 64'(exp_uid));
      chk("R7", "no second done", 64'(done_o), 0);
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk("R1", "ready in reset state", 64'(ready_o), 1);
    chk("R1", "outputs in reset state", {61'd0, done_o, crc_ok_o, id_ok_o}, 0);
    chk("R1", "uid in reset state", 64'(uid_o), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // model cross-check (R3): feeding the CRC byte through leaves zero
    make_vec(1, 1);
    chk("R3", "model residue", 64'(crc_ref(8)), 0);

    // directed: zero and all-ones unique numbers
    vec[0] = 8'hA0; for (int i = 1; i < 7; i++) vec[i] = 8'h00; vec[7] = crc_ref(7);
    run_vector(1, 0, 1);
    for (int i = 1; i < 7; i++) vec[i] = 8'hFF; vec[7] = crc_ref(7);
    run_vector(1, 1, 0);
    // wrong family byte (R4)
    make_vec(1, 1); vec[0] = 8'hA1; vec[7] = crc_ref(7);
    run_vector(1, 0, 0);
    // single-bit CRC errors at bit 0 and bit 7 (R3)
    make_vec(1, 1); vec[7] = vec[7] ^ 8'h01; run_vector(1, 0, 0);
    make_vec(1, 1); vec[7] = vec[7] ^ 8'h80; run_vector(1, 0, 1);

    // R8: start mid-byte discards partial check
    pulse_start();
    for (int i = 0; i < 3; i++) send_byte(8'($urandom), 0, 0);
    byte_valid_i = 1'b1; byte_i = 8'h5A;
    @(negedge clk);
    byte_valid_i = 1'b0;
    repeat (3) @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk("R8", "ready after abort", 64'(ready_o), 1);
    chk("R8", "no done after abort", 64'(done_o), 0);
    make_vec(1, 1);
    run_vector(0, 0, 0);

    // R8: strobe in the same cycle as start is not taken
    start_i = 1'b1; byte_valid_i = 1'b1; byte_i = 8'hA0;
    @(negedge clk);
    start_i = 1'b0; byte_valid_i = 1'b0;
    chk("R8", "byte with start ignored", 64'(ready_o), 1);
    make_vec(0, 1);
    run_vector(0, 0, 0);

    // constrained random
    for (int n = 0; n < 200; n++) begin
      make_vec($urandom_range(0, 3) != 0, $urandom_range(0, 2) != 0);
      run_vector(1, $urandom_range(0, 3) == 0, $urandom_range(0, 7) == 0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule